// File: doc/BRIEF.md
# External Interrupt Request Combiner

This block gathers one dedicated active-low interrupt pin and a set of optional port pins into a single interrupt request for a CPU. Each port pin becomes a source only when its static enable bit is set and its direction bit selects input. The dedicated pin and all qualified port pins are ANDed into one active-low combined level. A falling edge on that level sets a latch. The CPU clears the latch with a one-cycle acknowledge when it enters the service routine. A sensitivity input chooses between two modes. In edge-only mode the latch alone drives the request. In level mode a low combined level also drives the request.

All pins pass through a two-stage synchroniser before the combined level is formed. Because the sources share one edge detector, an edge on one source is seen only while every other qualified source is high. The combined level is also brought out as a status bit for bit-test instructions. The service vector address is a constant output.

The latch is a three-state machine:
- ST_WARM is entered at reset. It lasts until the synchroniser holds real pin values, and edges are ignored in it.
- ST_WARM goes to ST_IDLE after SYNC_STAGES+1 clocks.
- ST_IDLE goes to ST_PEND on a detected falling edge.
- ST_PEND goes to ST_IDLE on acknowledge, unless a new falling edge arrives in the same cycle. In that case it stays in ST_PEND.

Top module: `extirq_combiner`

## Requirements
- R1: `pin_status` is 0 when the dedicated pin or any qualified port pin is low, and 1 otherwise. A pin change reaches it after two clock edges.
- R2: A port pin is qualified only when its enable bit is 1 and its direction bit is 0 (input). A low level on an unqualified pin changes neither `pin_status` nor `irq_req`.
- R3: A falling edge of the combined level sets the latch. In edge-only mode `irq_req` rises three clock edges after the pin falls and stays high until acknowledged.
- R4: A falling edge on one source while another qualified source is already low sets nothing.
- R5: In edge-only mode (`level_mode`=0), `irq_req` is 0 after an acknowledge even while a source stays low.
- R6: In level mode (`level_mode`=1), `irq_req` is 1 whenever the combined level is low, including after an acknowledge.
- R7: An `irq_ack` pulse clears a set latch, and `irq_req` falls on the next clock edge in edge-only mode.
- R8: When `irq_ack` and a new falling edge fall on the same cycle, the latch stays set.
- R9: During and after reset, `irq_req` is 0 and `pin_status` is 1 while reset is asserted. A pin held low through reset never sets the latch.
- R10: `vector_addr` is constantly 16'h1FFA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Dedicated active-low interrupt pin |
| port_pin | input | NUM_PORT | Port pin levels, active-low as sources |
| port_src_en | input | NUM_PORT | Static per-pin source enable, 1 = enabled |
| port_dir_out | input | NUM_PORT | Per-pin direction, 1 = output (excluded) |
| level_mode | input | 1 | 0 = edge-only, 1 = edge plus level |
| irq_ack | input | 1 | One-cycle clear from CPU interrupt entry |
| irq_req | output | 1 | Interrupt request to the CPU |
| pin_status | output | 1 | Synchronised combined level for bit tests |
| vector_addr | output | 16 | Service vector address |

## Verification
The sweep covers every port pin, all four combinations of enable and direction bits, and both modes. It shows whether a pin is correctly qualified or excluded, whether the latch or the level path produced the request, and whether an acknowledge clears the request in edge-only mode but not in level mode. Directed patterns cover three further cases. A second source falls while a first is held low, which tells the shared edge detector apart from per-pin detection. A new edge lands on the acknowledge cycle, which shows which of the two wins. A pin held low through reset shows whether a spurious edge is produced.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
    typedef enum logic [1:0] {
        ST_WARM = 2'd0,
        ST_IDLE = 2'd1,
        ST_PEND = 2'd2
    } latch_state_t;

    localparam logic [15:0] IRQ_VECTOR = 16'h1FFA;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Idle (high) value at reset: sources are active-low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/extirq_merge.sv
module extirq_merge #(
    parameter int NUM_PORT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ded_n,
    input  logic [NUM_PORT-1:0] port_n,
    input  logic [NUM_PORT-1:0] src_en,
    input  logic [NUM_PORT-1:0] dir_out,
    output logic                comb_n
);
    logic [NUM_PORT-1:0] masked;

    genvar g;
    generate
        for (g = 0; g < NUM_PORT; g++) begin : g_qual
            // An unqualified pin reads as high (inactive).
            assign masked[g] = port_n[g] | ~src_en[g] | dir_out[g];
        end
    endgenerate

    assign comb_n = ded_n & (&masked);

    AST_LOW_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !comb_n |-> (!ded_n || ((~port_n & src_en & ~dir_out) != '0))); // R1
    AST_OUTPUT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ded_n && ((~port_n & src_en & ~dir_out) == '0)) |-> comb_n); // R2
endmodule

// File: rtl/extirq_latch.sv
module extirq_latch
    import extirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic comb_n,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(SYNC_STAGES + 1) + 1;
    localparam logic [CW-1:0] WARM_LAST = CW'(SYNC_STAGES);

    latch_state_t state, state_nx;
    logic [CW-1:0] warm_cnt;
    logic          prev_n;
    logic          fall;

    assign fall = prev_n & ~comb_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_WARM;
            warm_cnt <= '0;
            prev_n   <= 1'b1;
        end else begin
            state    <= state_nx;
            prev_n   <= comb_n;
            if (state == ST_WARM) begin
                warm_cnt <= warm_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WARM: if (warm_cnt == WARM_LAST) state_nx = ST_IDLE;
            ST_IDLE: if (fall) state_nx = ST_PEND;
            ST_PEND: if (ack && !fall) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = (state == ST_PEND);
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WARM && fall) |=> (state == ST_PEND)); // R3
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND && !ack) |=> (state == ST_PEND)); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND && ack && !fall) |=> (state == ST_IDLE)); // R7
    AST_ACK_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND && ack && fall) |=> (state == ST_PEND)); // R8
    AST_WARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WARM) |=> (state != ST_PEND)); // R9
endmodule

// File: rtl/extirq_combiner.sv
module extirq_combiner
    import extirq_pkg::*;
#(
    parameter int NUM_PORT    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_pin_n,
    input  logic [NUM_PORT-1:0] port_pin,
    input  logic [NUM_PORT-1:0] port_src_en,
    input  logic [NUM_PORT-1:0] port_dir_out,
    input  logic                level_mode,
    input  logic                irq_ack,
    output logic                irq_req,
    output logic                pin_status,
    output logic [15:0]         vector_addr
);
    localparam int SW = NUM_PORT + 1;

    logic [SW-1:0] sync_q;
    logic          comb_n;
    logic          pending;

    extirq_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({irq_pin_n, port_pin}),
        .q     (sync_q)
    );

    extirq_merge #(.NUM_PORT(NUM_PORT)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ded_n   (sync_q[SW-1]),
        .port_n  (sync_q[NUM_PORT-1:0]),
        .src_en  (port_src_en),
        .dir_out (port_dir_out),
        .comb_n  (comb_n)
    );

    extirq_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .comb_n  (comb_n),
        .ack     (irq_ack),
        .pending (pending)
    );

    assign irq_req     = pending | (level_mode & ~comb_n);
    assign pin_status  = comb_n;
    assign vector_addr = IRQ_VECTOR;

    AST_LEVEL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !pin_status) |-> irq_req); // R6
    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && $past(irq_req) && !irq_req) |-> $past(irq_ack)); // R5
endmodule

// File: tb/tb_extirq_combiner.sv
module tb_extirq_combiner;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         irq_pin_n;
    logic [N-1:0] port_pin;
    logic [N-1:0] port_src_en;
    logic [N-1:0] port_dir_out;
    logic         level_mode;
    logic         irq_ack;
    logic         irq_req;
    logic         pin_status;
    logic [15:0]  vector_addr;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    extirq_combiner #(.NUM_PORT(N), .SYNC_STAGES(2)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_pin_n    (irq_pin_n),
        .port_pin     (port_pin),
        .port_src_en  (port_src_en),
        .port_dir_out (port_dir_out),
        .level_mode   (level_mode),
        .irq_ack      (irq_ack),
        .irq_req      (irq_req),
        .pin_status   (pin_status),
        .vector_addr  (vector_addr)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        tick(1);
    endtask

    initial begin
        rst_n        = 1'b0;
        irq_pin_n    = 1'b0;
        port_pin     = '1;
        port_src_en  = '0;
        port_dir_out = '0;
        level_mode   = 1'b0;
        irq_ack      = 1'b0;
        tick(3);
        chk("R9 req in reset", {15'd0, irq_req}, 16'd0);
        chk("R9 status in reset", {15'd0, pin_status}, 16'd1);
        rst_n = 1'b1;
        tick(8);
        chk("R1 status low pin", {15'd0, pin_status}, 16'd0);
        chk("R9 no spurious edge", {15'd0, irq_req}, 16'd0);
        chk("R10 vector", vector_addr, 16'h1FFA);
        irq_pin_n = 1'b1;
        tick(5);

        // Sweep: mode x pin x (enable, direction)
        for (int lv = 0; lv < 2; lv++) begin
            for (int i = 0; i < N; i++) begin
                for (int cfg = 0; cfg < 4; cfg++) begin
                    logic q;
                    q = (cfg == 1);
                    level_mode      = lv[0];
                    port_src_en     = '1;
                    port_dir_out    = '0;
                    port_src_en[i]  = cfg[0];
                    port_dir_out[i] = cfg[1];
                    port_pin        = '1;
                    tick(5);
                    pulse_ack();
                    port_pin[i] = 1'b0;
                    tick(5);
                    chk("R1 R2 status", {15'd0, pin_status}, {15'd0, ~q});
                    chk(lv ? "R6 R2 req" : "R3 R2 req", {15'd0, irq_req}, {15'd0, q});
                    pulse_ack();
                    chk(lv ? "R6 req after ack" : "R5 req after ack",
                        {15'd0, irq_req}, {15'd0, q & lv[0]});
                    port_pin[i] = 1'b1;
                    tick(5);
                    pulse_ack();
                    chk("R7 cleared", {15'd0, irq_req}, 16'd0);
                end
            end
        end

        // Dedicated pin edge, edge-only mode
        level_mode   = 1'b0;
        port_src_en  = '1;
        port_dir_out = '0;
        port_pin     = '1;
        tick(5);
        pulse_ack();
        irq_pin_n = 1'b0;
        tick(2);
        chk("R3 no req before third edge", {15'd0, irq_req}, 16'd0);
        tick(1);
        chk("R3 dedicated edge", {15'd0, irq_req}, 16'd1);
        irq_pin_n = 1'b1;
        tick(5);
        chk("R3 latch holds", {15'd0, irq_req}, 16'd1);
        pulse_ack();
        chk("R7 ack clears", {15'd0, irq_req}, 16'd0);

        // Masking by another low source
        port_pin[0] = 1'b0;
        tick(5);
        pulse_ack();
        chk("R5 low source no req", {15'd0, irq_req}, 16'd0);
        port_pin[1] = 1'b0;
        tick(5);
        chk("R4 masked edge", {15'd0, irq_req}, 16'd0);
        port_pin = '1;
        tick(5);
        chk("R4 rising no req", {15'd0, irq_req}, 16'd0);
        port_pin[1] = 1'b0;
        tick(5);
        chk("R3 unmasked edge", {15'd0, irq_req}, 16'd1);
        port_pin = '1;
        tick(5);
        pulse_ack();

        // Acknowledge coinciding with a new edge
        port_pin[0] = 1'b0;
        tick(5);
        port_pin[0] = 1'b1;
        tick(5);
        chk("R8 pending before", {15'd0, irq_req}, 16'd1);
        port_pin[2] = 1'b0;
        tick(2);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        tick(1);
        chk("R8 edge beats ack", {15'd0, irq_req}, 16'd1);
        pulse_ack();
        chk("R7 later ack clears", {15'd0, irq_req}, 16'd0);
        chk("R10 vector", vector_addr, 16'h1FFA);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule